// File: doc/BRIEF.md
# I2C Target Engine with Software-Driven Controller Mode

This block joins a two-wire serial bus through open-drain pull-down enables and is run by software over a small byte-wide register port. It resets into target mode. In that mode a hardware engine watches the bus for START, repeated START and STOP. It compares each incoming 7-bit address with four programmable address slots and with the general call address, then shifts data bytes in or out. Between bytes it holds SCL low until software has dealt with the byte.

Each event raises one interrupt flag and leaves a 2-bit code that tells software what happened. A read or a write of the data register counts as servicing the event and clears the flag. A second access to the data register for the same event is a software fault: the engine halts until a soft reset.

Setting the mode bit stops the hardware engine and gives software direct control of both wires. One register bit sets the SCL level. Another bit sets the SDA level and a third bit switches the SDA driver on. The SDA input is captured on every rising edge of SCL. Both bus inputs pass through a two-flop synchronizer.

Top module: `i2c_slave_bb`

## Requirements
- R1: After reset the block is in target mode, SCL and SDA are not pulled, and the interrupt flag is clear. The control register (offset 0) reads 0x18. The status register (offset 1) reads 0x00. Address slot 0 (offset 3) reads 0x55. Slots 1 to 3 (offsets 4 to 6) read 0x00.
- R2: After the 8th SCL rise of the first byte, the 7-bit address is checked. If it equals any slot or zero, the flag is set, the data register (offset 2) holds the whole address byte, and the status direction bit (bit 3) equals the R/W bit. Any other address gets no ACK and no flag, and the engine waits for the next START.
- R3: The source code is in status bits 2:1. Its values are 00 for a START with a matching address, 01 for a repeated START with a matching address, 10 for a data byte, and 11 for a STOP.
- R4: In receive direction the target drives ACK on the 9th clock of every byte it accepts. After each received data byte the flag is set with code 10, and the data register holds the byte.
- R5: In transmit direction the target shifts the data register out MSB first. When the controller ACKs, the flag is set with code 10. When it NACKs, no flag is set and the engine goes idle.
- R6: If the flag is still set at the end of a byte, the target holds SCL low. A read or write of the data register clears the flag and releases SCL.
- R7: A STOP always returns the engine to idle. It sets the flag with code 11 only when the stop-interrupt enable (control bit 1) is set and the transfer began with a matching address. Writing status bit 0 as 1 clears the flag.
- R8: A second data-register access for one event sets the halt bit (status bit 5). While halted the engine ignores the bus and pulls neither line. Writing control bit 2 as 1 clears the halt and sends the engine back to idle.
- R9: Reception of the general call address sets status bit 4. The bit stays set until software writes status bit 4 as 1.
- R10: With control bit 0 set, control bit 3 is the SCL level, control bit 4 is the SDA level, and control bit 5 enables the SDA driver. A level of 0 pulls the line low.
- R11: In controller mode with the SDA driver off, the SDA line is copied into control bit 6 on each SCL rising edge. SDA changes while SCL is steady leave bit 6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks a data-register read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
On every cycle the assertions check four things. The halt bit stays set until a soft reset, and a halted engine pulls neither line. The general call bit stays set until software clears it. SCL is released right after a data-register access. They also check that the captured SDA bit changes only in controller mode, and that the SCL enable follows the control bit. Only the bench scenarios can show the rest. That covers address matching over the whole 7-bit space, correct source codes for START, repeated START and STOP, and data order in both directions. It also covers the NACK exit and the SDA capture timing in controller mode.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // register offsets; slots occupy REG_SLOT0 upward
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_DATA  = 3'd2;
  localparam logic [2:0] REG_SLOT0 = 3'd3;

  localparam logic [1:0] SRC_START  = 2'b00;
  localparam logic [1:0] SRC_RSTART = 2'b01;
  localparam logic [1:0] SRC_DATA   = 2'b10;
  localparam logic [1:0] SRC_STOP   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RACK, ST_RX, ST_TLOAD, ST_TX, ST_TACK
  } eng_st_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '1;
      prev_q <= '1;
    end else begin
      st_q[0] <= din;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      prev_q <= st_q[STAGES-1];
    end
  end

  assign cur  = st_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/i2cs_match.sv
module i2cs_match #(
  parameter int N  = 4,
  parameter int AW = 7
) (
  input  logic [N*AW-1:0] slots,
  input  logic [AW-1:0]   cand,
  output logic            hit,
  output logic            gcall
);
  logic [N-1:0] hit_v;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_v[g] = (slots[g*AW +: AW] == cand);
  end

  assign gcall = (cand == '0);
  assign hit   = (|hit_v) | gcall;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       en,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_p,
  input  logic       sda_p,
  input  logic       irq_pend,
  input  logic       stop_ie,
  input  logic [7:0] tx_byte,
  input  logic       hit,
  output logic [6:0] cand,
  output logic       hw_irq,
  output logic [1:0] hw_src,
  output logic       hw_cap,
  output logic [7:0] hw_byte,
  output logic       hw_addr,
  output logic       hw_dir,
  output logic       sda_pull,
  output logic       scl_pull
);
  eng_st_t     st_q, st_d;
  logic [2:0]  cnt_q, cnt_d;
  logic [1:0]  sub_q, sub_d;
  logic [7:0]  sr_q, sr_d;
  logic        act_q, act_d, rep_q, rep_d, dir_q, dir_d;
  logic        ack_q, ack_d, str_q, str_d;
  logic        start_ev, stop_ev, rise, fall;

  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise     = scl_s & ~scl_p;
  assign fall     = ~scl_s & scl_p;
  assign cand     = sr_q[6:0];
  assign hw_byte  = {sr_q[6:0], sda_s};
  assign hw_dir   = sda_s;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sub_d = sub_q; sr_d = sr_q;
    act_d = act_q; rep_d = rep_q; dir_d = dir_q; ack_d = ack_q;
    str_d = str_q & irq_pend;
    hw_irq = 1'b0; hw_src = SRC_DATA; hw_cap = 1'b0; hw_addr = 1'b0;
    if (!en) begin
      st_d = ST_IDLE; act_d = 1'b0; ack_d = 1'b0; str_d = 1'b0;
    end else if (stop_ev) begin
      if (act_q && stop_ie) begin hw_irq = 1'b1; hw_src = SRC_STOP; end
      st_d = ST_IDLE; act_d = 1'b0; ack_d = 1'b0; str_d = 1'b0;
    end else if (start_ev) begin
      st_d = ST_ADDR; cnt_d = '0; rep_d = act_q; ack_d = 1'b0; str_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (rise) begin
          sr_d = hw_byte; cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (hit) begin
              hw_irq = 1'b1; hw_cap = 1'b1; hw_addr = 1'b1;
              hw_src = rep_q ? SRC_RSTART : SRC_START;
              act_d = 1'b1; dir_d = sda_s; st_d = ST_RACK; sub_d = 2'd0;
            end else begin
              st_d = ST_IDLE; act_d = 1'b0;
            end
          end
        end
        ST_RACK: begin
          if (sub_q == 2'd0 && fall) begin
            sub_d = 2'd1; ack_d = 1'b1; str_d = 1'b1;
          end else if (sub_q == 2'd1 && rise) begin
            sub_d = 2'd2;
          end else if (sub_q == 2'd2 && fall) begin
            ack_d = 1'b0; cnt_d = '0;
            st_d = dir_q ? ST_TLOAD : ST_RX;
          end
        end
        ST_RX: if (rise) begin
          sr_d = hw_byte; cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            hw_irq = 1'b1; hw_cap = 1'b1; st_d = ST_RACK; sub_d = 2'd0;
          end
        end
        ST_TLOAD: if (!irq_pend) begin
          sr_d = tx_byte; cnt_d = '0; st_d = ST_TX;
        end
        ST_TX: if (fall) begin
          sr_d = {sr_q[6:0], 1'b1}; cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin st_d = ST_TACK; sub_d = 2'd0; end
        end
        ST_TACK: begin
          if (sub_q == 2'd0 && rise) begin
            if (!sda_s) begin hw_irq = 1'b1; sub_d = 2'd1; end
            else st_d = ST_IDLE;
          end else if (sub_q == 2'd1 && fall) begin
            str_d = 1'b1; st_d = ST_TLOAD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sub_q <= '0; sr_q <= '1;
      act_q <= 1'b0; rep_q <= 1'b0; dir_q <= 1'b0; ack_q <= 1'b0; str_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sub_q <= sub_d; sr_q <= sr_d;
      act_q <= act_d; rep_q <= rep_d; dir_q <= dir_d; ack_q <= ack_d; str_q <= str_d;
    end
  end

  assign sda_pull = ack_q | ((st_q == ST_TX) & ~sr_q[7]);
  assign scl_pull = str_q & irq_pend;
endmodule

// File: rtl/i2c_slave_bb.sv
module i2c_slave_bb
  import i2cs_pkg::*;
#(
  parameter int             NUM_SLOTS   = 4,
  parameter int             ADDR_W      = 7,
  parameter int             SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SLOT0_RST = 7'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int SLOT_BITS = NUM_SLOTS * ADDR_W;

  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic scl_s, sda_s, scl_p, sda_p;
  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .din({scl_i, sda_i}),
    .cur({scl_s, sda_s}), .prev({scl_p, sda_p})
  );

  logic mode_q, mode_d, sie_q, sie_d, mscl_q, mscl_d, msdo_q, msdo_d;
  logic msen_q, msen_d, msdi_q, msdi_d;
  logic irq_q, irq_d, dir_q, dir_d, gc_q, gc_d, halt_q, halt_d, acc_q, acc_d;
  logic [1:0] src_q, src_d;
  logic [7:0] data_q, data_d;
  logic [ADDR_W-1:0] slot_q [NUM_SLOTS];
  logic [ADDR_W-1:0] slot_d [NUM_SLOTS];
  logic [SLOT_BITS-1:0] slot_flat;
  logic sreset, data_acc, eng_en;

  logic [6:0] cand;
  logic hit, gcall, hw_irq, hw_cap, hw_addr, hw_dir, sda_pull, scl_pull;
  logic [1:0] hw_src;
  logic [7:0] hw_byte;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
    assign slot_flat[g*ADDR_W +: ADDR_W] = slot_q[g];
  end

  i2cs_match #(.N(NUM_SLOTS), .AW(ADDR_W)) u_match (
    .slots(slot_flat), .cand(cand), .hit(hit), .gcall(gcall)
  );

  assign sreset   = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[2];
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == REG_DATA);
  assign eng_en   = ~mode_q & ~halt_q & ~sreset;

  i2cs_engine u_eng (
    .clk(clk), .rst_ni(rst_ni), .en(eng_en),
    .scl_s(scl_s), .sda_s(sda_s), .scl_p(scl_p), .sda_p(sda_p),
    .irq_pend(irq_q), .stop_ie(sie_q), .tx_byte(data_q), .hit(hit),
    .cand(cand), .hw_irq(hw_irq), .hw_src(hw_src), .hw_cap(hw_cap),
    .hw_byte(hw_byte), .hw_addr(hw_addr), .hw_dir(hw_dir),
    .sda_pull(sda_pull), .scl_pull(scl_pull)
  );

  always_comb begin
    mode_d = mode_q; sie_d = sie_q; mscl_d = mscl_q; msdo_d = msdo_q;
    msen_d = msen_q; msdi_d = msdi_q; irq_d = irq_q; src_d = src_q;
    dir_d = dir_q; gc_d = gc_q; halt_d = halt_q; acc_d = acc_q; data_d = data_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_d[i] = slot_q[i];
      if (reg_wr && reg_addr == 3'(REG_SLOT0 + i)) slot_d[i] = reg_wdata[ADDR_W-1:0];
    end
    if (reg_wr) begin
      unique case (reg_addr)
        REG_CTRL: begin
          mode_d = reg_wdata[0]; sie_d = reg_wdata[1]; mscl_d = reg_wdata[3];
          msdo_d = reg_wdata[4]; msen_d = reg_wdata[5];
        end
        REG_STAT: begin
          if (reg_wdata[0]) irq_d = 1'b0;
          if (reg_wdata[4]) gc_d = 1'b0;
        end
        REG_DATA: data_d = reg_wdata;
        default: ;
      endcase
    end
    if (data_acc) begin
      if (acc_q) halt_d = 1'b1;
      else begin acc_d = 1'b1; irq_d = 1'b0; end
    end
    if (sreset) begin halt_d = 1'b0; acc_d = 1'b0; end
    if (hw_cap) data_d = hw_byte;
    if (hw_addr) begin dir_d = hw_dir; if (gcall) gc_d = 1'b1; end
    if (hw_irq) begin irq_d = 1'b1; src_d = hw_src; acc_d = 1'b0; end
    if (mode_q && scl_s && !scl_p && !msen_q) msdi_d = sda_s;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0; sie_q <= 1'b0; mscl_q <= 1'b1; msdo_q <= 1'b1;
      msen_q <= 1'b0; msdi_q <= 1'b0; irq_q <= 1'b0; src_q <= '0;
      dir_q <= 1'b0; gc_q <= 1'b0; halt_q <= 1'b0; acc_q <= 1'b0; data_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= (i == 0) ? SLOT0_RST : '0;
    end else begin
      mode_q <= mode_d; sie_q <= sie_d; mscl_q <= mscl_d; msdo_q <= msdo_d;
      msen_q <= msen_d; msdi_q <= msdi_d; irq_q <= irq_d; src_q <= src_d;
      dir_q <= dir_d; gc_q <= gc_d; halt_q <= halt_d; acc_q <= acc_d; data_q <= data_d;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= slot_d[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_CTRL: reg_rdata = {1'b0, msdi_q, msen_q, msdo_q, mscl_q, 1'b0, sie_q, mode_q};
      REG_STAT: reg_rdata = {2'b00, halt_q, gc_q, dir_q, src_q, irq_q};
      REG_DATA: reg_rdata = data_q;
      default:
        for (int i = 0; i < NUM_SLOTS; i++)
          if (reg_addr == 3'(REG_SLOT0 + i)) reg_rdata = 8'(slot_q[i]);
    endcase
  end

  assign irq    = irq_q;
  assign scl_oe = mode_q ? ~mscl_q : scl_pull;
  assign sda_oe = mode_q ? (msen_q & ~msdo_q) : sda_pull;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       mode_q,
  input logic       halt_q,
  input logic       irq_q,
  input logic       acc_q,
  input logic       gc_q,
  input logic       msdi_q,
  input logic       mscl_q,
  input logic       data_acc,
  input logic       scl_oe,
  input logic       sda_oe
);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (halt_q && !(reg_wr && reg_addr == 3'd0 && reg_wdata[2])) |=> halt_q);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (halt_q && $past(halt_q) && !mode_q) |-> (!scl_oe && !sda_oe));

  assert_irq_fresh_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_q) |-> !acc_q);

  assert_scl_release_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_q && data_acc) |=> !scl_oe);

  assert_gc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (gc_q && !(reg_wr && reg_addr == 3'd1 && reg_wdata[4])) |=> gc_q);

  assert_sdain_mode_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (msdi_q != $past(msdi_q)) |-> $past(mode_q));

  assert_scl_follow_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q && $past(mode_q) && $stable(mscl_q)) |-> $stable(scl_oe));
endmodule

bind i2c_slave_bb i2cs_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_q(mode_q), .halt_q(halt_q), .irq_q(irq_q),
  .acc_q(acc_q), .gc_q(gc_q), .msdi_q(msdi_q), .mscl_q(mscl_q),
  .data_acc(data_acc), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_i2c_slave_bb.sv
module sim_i2c_slave_bb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WD_CYCLES = 190000;

  logic clk, rst_n, reg_wr, reg_rd, irq, scl_oe, sda_oe;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic scl_m, sda_m, scl_ln, sda_ln;
  int errors, checks;

  assign scl_ln = scl_m & ~scl_oe;
  assign sda_ln = sda_m & ~sda_oe;

  i2c_slave_bb u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_scl;
    int n;
    n = 0;
    while (!scl_ln && n < 3000) begin @(negedge clk); n++; end
    if (!scl_ln) chk("R6 SCL never released", 0, 1);
  endtask

  task automatic i_start;
    sda_m = 1'b1; scl_m = 1'b1; waitn(Q);
    sda_m = 1'b0; waitn(Q); scl_m = 1'b0; waitn(Q);
  endtask

  task automatic i_rstart;
    sda_m = 1'b1; waitn(Q); scl_m = 1'b1; wait_scl; waitn(Q);
    sda_m = 1'b0; waitn(Q); scl_m = 1'b0; waitn(Q);
  endtask

  task automatic i_stop;
    sda_m = 1'b0; waitn(Q); scl_m = 1'b1; wait_scl; waitn(Q);
    sda_m = 1'b1; waitn(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; waitn(Q); scl_m = 1'b1; wait_scl; waitn(Q);
    r = sda_ln; scl_m = 1'b0; waitn(Q);
  endtask

  task automatic send8(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
  endtask

  task automatic recv8(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); v[i] = r; end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic r;
    logic exp_hit;
    errors = 0; checks = 0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    waitn(4); rst_n = 1'b1; waitn(4);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl reset", v, 8'h18);
    rd(3'd1, v); chk("R1 stat reset", v, 8'h00);
    rd(3'd3, v); chk("R1 slot0 reset", v, 8'h55);
    for (int i = 4; i <= 6; i++) begin rd(3'(i), v); chk("R1 slot reset", v, 0); end
    chk("R1 lines released", {scl_oe, sda_oe, irq}, 0);

    wr(3'd4, 8'h12); wr(3'd5, 8'h6C); wr(3'd6, 8'h3B);
    rd(3'd5, v); chk("R2 slot write", v, 8'h6C);

    // R2 sweep of the whole address space (write direction)
    for (int a = 0; a < 128; a++) begin
      exp_hit = (a == 8'h55) || (a == 8'h12) || (a == 8'h6C) || (a == 8'h3B) || (a == 0);
      i_start;
      send8({7'(a), 1'b0});
      chk("R2 flag on match", irq, exp_hit);
      if (exp_hit) begin
        rd(3'd1, v); chk("R2 R3 R9 status after address", v, (a == 0) ? 8'h11 : 8'h01);
        rd(3'd2, v); chk("R2 data holds address", v, {7'(a), 1'b0});
      end
      clk_bit(1'b1, r); chk("R2 ack", r, !exp_hit);
      i_stop;
      if (a == 0) begin
        wr(3'd1, 8'h10); rd(3'd1, v); chk("R9 gc cleared", v[4], 0);
      end
    end

    // R4 R6 R7 receive transfer with stop interrupt
    wr(3'd0, 8'h1A);
    i_start; send8({7'h12, 1'b0});
    rd(3'd2, v); chk("R4 address byte", v, 8'h24);
    clk_bit(1'b1, r); chk("R4 address ack", r, 0);
    send8(8'hA5);
    chk("R6 SCL held", scl_oe, 1);
    waitn(40); chk("R6 SCL still low", scl_ln, 0);
    rd(3'd1, v); chk("R3 R4 data code", v & 8'h07, 8'h05);
    rd(3'd2, v); chk("R4 byte A5", v, 8'hA5);
    waitn(1); chk("R6 SCL released", {scl_oe, irq}, 0);
    clk_bit(1'b1, r); chk("R4 data ack", r, 0);
    send8(8'h3C);
    rd(3'd2, v); chk("R4 byte 3C", v, 8'h3C);
    clk_bit(1'b1, r); chk("R4 data ack 2", r, 0);
    i_stop; waitn(2);
    rd(3'd1, v); chk("R3 R7 stop code", v & 8'h07, 8'h07);
    wr(3'd1, 8'h01); chk("R7 flag cleared", irq, 0);

    // R3 R5 repeated start and transmit
    i_start; send8({7'h6C, 1'b0});
    rd(3'd2, v); clk_bit(1'b1, r);
    send8(8'h11); rd(3'd2, v); chk("R4 byte 11", v, 8'h11);
    clk_bit(1'b1, r);
    i_rstart; send8({7'h6C, 1'b1});
    rd(3'd1, v); chk("R3 R2 repeated start code and direction", v & 8'h0F, 8'h0B);
    wr(3'd2, 8'hC3);
    clk_bit(1'b1, r); chk("R5 address ack", r, 0);
    recv8(v); chk("R5 first byte", v, 8'hC3);
    clk_bit(1'b0, r); waitn(2);
    chk("R5 flag on controller ack", irq, 1);
    rd(3'd1, v); chk("R5 code on ack", v & 8'h07, 8'h05);
    wr(3'd2, 8'h81);
    recv8(v); chk("R5 second byte", v, 8'h81);
    clk_bit(1'b1, r); waitn(4);
    chk("R5 no flag on nack", irq, 0);
    i_stop; waitn(2);
    rd(3'd1, v); chk("R7 stop after read", v & 8'h07, 8'h07);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h18);

    // R8 double access halt and soft reset
    i_start; send8({7'h55, 1'b0});
    rd(3'd2, v); rd(3'd2, v);
    rd(3'd1, v); chk("R8 halt set", v[5], 1);
    clk_bit(1'b1, r); chk("R8 no ack while halted", r, 1);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    i_stop;
    wr(3'd0, 8'h1C);
    rd(3'd1, v); chk("R8 halt cleared", v[5], 0);
    i_start; send8({7'h55, 1'b0});
    chk("R8 works after soft reset", irq, 1);
    rd(3'd2, v); clk_bit(1'b1, r); chk("R8 ack after soft reset", r, 0);
    i_stop;

    // R10 R11 controller mode
    wr(3'd0, 8'h21); waitn(1);
    chk("R10 both pulled", {scl_oe, sda_oe}, 2'b11);
    wr(3'd0, 8'h29); waitn(1);
    chk("R10 scl high sda low", {scl_oe, sda_oe}, 2'b01);
    wr(3'd0, 8'h39); waitn(1);
    chk("R10 both high", {scl_oe, sda_oe}, 2'b00);
    sda_m = 1'b0;
    wr(3'd0, 8'h01); wr(3'd0, 8'h09); waitn(5);
    rd(3'd0, v); chk("R11 sampled 0", v[6], 0);
    sda_m = 1'b1; waitn(10);
    rd(3'd0, v); chk("R11 no sample without edge", v[6], 0);
    wr(3'd0, 8'h01); wr(3'd0, 8'h09); waitn(5);
    rd(3'd0, v); chk("R11 sampled 1", v[6], 1);
    wr(3'd0, 8'h18); waitn(1);
    chk("R10 back to target mode", {scl_oe, sda_oe}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule